// File: doc/BRIEF.md
# Serial Auto-Increment Register Loader

This block is a write-only serial slave for an on-screen display controller. A host frames each transfer by pulling chip select low, then clocks 16-bit words in on a serial data pin. The first word of a transfer selects a start location in a 192-word space. Locations 0 to 175 hold display character memory and locations 176 to 191 hold control registers. Every later word in the same transfer is written to the current location, and the location then advances by one.

The block trims each data word to the width that its target location stores. It hands every write to the downstream memory as one beat on a valid/ready stream. It also raises a one-cycle clear request when a host sets the system-clear bit of the mode register. The serial pins are asynchronous to the system clock and pass through synchronizers first.

Back-pressure rules: once `wr_valid` is high, `wr_addr` and `wr_data` hold steady until a cycle in which `wr_ready` is high. The serial side cannot be stalled. A data word that completes while an earlier beat is still waiting is discarded, and the location counter still advances past it.

Top module: `osd_serial_loader`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wr_valid` and `clr_all` are low and the next transfer begins with a location word.
- R2: Bits are taken most-significant first on rising edges of `ser_clk`, and only while `ser_cs_n` is low. Clock edges while `ser_cs_n` is high have no effect. All three serial inputs pass through a two-flop synchronizer.
- R3: The first 16-bit word after `ser_cs_n` falls is the start location, taken from bits 7..0. If bits 15..8 of that word are not all zero, every remaining word of the transfer is ignored until `ser_cs_n` rises.
- R4: Each later word in the transfer produces one write at the current location, and the location then increments by one.
- R5: Write data keeps bits 7..0 for locations 0x00 to 0xAF, bits 10..0 for 0xB0 to 0xBB, and bits 11..0 for 0xBC to 0xBF. All higher bits are zero.
- R6: No write is issued for a location of 192 or more. The location counter stops at 192 and does not wrap back to 0.
- R7: A word left incomplete when `ser_cs_n` rises is discarded. The next fall of `ser_cs_n` starts a new location word.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. A data word that completes during that wait is dropped, but the location still advances.
- R9: A data word written to location 190 (0xBE) with bit 5 set raises `clr_all` for exactly one cycle. This happens even if the word is dropped. The word itself is still delivered as a normal write.
- R10: With `wr_ready` high, a write appears on `wr_valid` no later than 6 clock cycles after the rising `ser_clk` edge of its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ser_cs_n | input | 1 | Serial chip select, active low, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| wr_valid | output | 1 | A write beat is presented |
| wr_ready | input | 1 | Downstream memory accepts the beat |
| wr_addr | output | 8 | Target location of the beat |
| wr_data | output | 16 | Width-trimmed write data |
| clr_all | output | 1 | One-cycle request to clear all registers |

## Verification
A bit counter that has slipped shows up as misaligned data on the very next write beat. An unrecovered partial word also shows up there, after the next location word. A location counter that is off, or that has wrapped, shows up as the wrong `wr_addr` on the first beat that follows. A wrong range boundary leaves stray upper bits in `wr_data` right at the location where the width changes. A lost hold under back-pressure changes the waiting beat within one cycle. A mistracked drop shows up as a shifted address on the first beat after `wr_ready` returns.

// File: rtl/osd_ld_pkg.sv
package osd_ld_pkg;
  localparam int WORD_W_DEF    = 16;
  localparam int ADDR_W_DEF    = 8;
  localparam int SPACE_DEF     = 192;
  localparam int RAM_WORDS_DEF = 176;
  localparam int WIDE_BASE_DEF = 188;
  localparam int RAM_DW_DEF    = 8;
  localparam int CTRL_DW_DEF   = 11;
  localparam int WIDE_DW_DEF   = 12;
  localparam int CLR_ADDR_DEF  = 190;
  localparam int CLR_BIT_DEF   = 5;

  typedef enum logic [1:0] {
    PH_LOC  = 2'd0,
    PH_DATA = 2'd1,
    PH_SKIP = 2'd2
  } ld_phase_e;
endpackage

// File: rtl/osd_ld_sync.sv
module osd_ld_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/osd_ld_shifter.sv
module osd_ld_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic              word_done,
  output logic [WORD_W-1:0] word_q
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             sclk_prev;
  logic             rise;
  logic [CNT_W-1:0] bit_cnt;

  assign rise = sclk_s & ~sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      bit_cnt   <= '0;
      word_q    <= '0;
      word_done <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      word_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (rise) begin
        word_q <= {word_q[WORD_W-2:0], sdat_s};
        if (bit_cnt == LAST) begin
          bit_cnt   <= '0;
          word_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/osd_ld_framer.sv
module osd_ld_framer
  import osd_ld_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int SPACE     = 192,
  parameter int RAM_WORDS = 176,
  parameter int WIDE_BASE = 188,
  parameter int RAM_DW    = 8,
  parameter int CTRL_DW   = 11,
  parameter int WIDE_DW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_q,
  output logic              cmd_fire,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data
);
  localparam logic [WORD_W-1:0] M_RAM  = WORD_W'((64'd1 << RAM_DW) - 1);
  localparam logic [WORD_W-1:0] M_CTRL = WORD_W'((64'd1 << CTRL_DW) - 1);
  localparam logic [WORD_W-1:0] M_WIDE = WORD_W'((64'd1 << WIDE_DW) - 1);

  ld_phase_e         phase;
  logic [ADDR_W-1:0] loc;
  logic              in_space;
  logic              upper_clear;
  logic [WORD_W-1:0] mask;

  assign in_space    = int'(loc) < SPACE;
  assign upper_clear = (word_q[WORD_W-1:ADDR_W] == '0);

  always_comb begin
    if (int'(loc) < RAM_WORDS)      mask = M_RAM;
    else if (int'(loc) < WIDE_BASE) mask = M_CTRL;
    else                            mask = M_WIDE;
  end

  assign cmd_fire = word_done && !cs_n_s && (phase == PH_DATA) && in_space;
  assign cmd_addr = loc;
  assign cmd_data = word_q & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOC;
      loc   <= '0;
    end else if (cs_n_s) begin
      phase <= PH_LOC;
    end else if (word_done) begin
      unique case (phase)
        PH_LOC: begin
          if (upper_clear) begin
            loc   <= word_q[ADDR_W-1:0];
            phase <= PH_DATA;
          end else begin
            phase <= PH_SKIP;
          end
        end
        PH_DATA: begin
          if (in_space) loc <= loc + 1'b1;
        end
        default: phase <= PH_SKIP;
      endcase
    end
  end
endmodule

// File: rtl/osd_ld_outslot.sv
module osd_ld_outslot #(
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 8,
  parameter int CLR_ADDR = 190,
  parameter int CLR_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              clr_all
);
  localparam logic [ADDR_W-1:0] CLR_LOC = ADDR_W'(CLR_ADDR);

  logic slot_free;
  assign slot_free = !wr_valid || wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      clr_all  <= 1'b0;
    end else begin
      clr_all <= cmd_fire && (cmd_addr == CLR_LOC) && cmd_data[CLR_BIT];
      if (cmd_fire && slot_free) begin
        wr_valid <= 1'b1;
        wr_addr  <= cmd_addr;
        wr_data  <= cmd_data;
      end else if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/osd_serial_loader.sv
module osd_serial_loader
  import osd_ld_pkg::*;
#(
  parameter int WORD_W      = WORD_W_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int SPACE       = SPACE_DEF,
  parameter int RAM_WORDS   = RAM_WORDS_DEF,
  parameter int WIDE_BASE   = WIDE_BASE_DEF,
  parameter int RAM_DW      = RAM_DW_DEF,
  parameter int CTRL_DW     = CTRL_DW_DEF,
  parameter int WIDE_DW     = WIDE_DW_DEF,
  parameter int CLR_ADDR    = CLR_ADDR_DEF,
  parameter int CLR_BIT     = CLR_BIT_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_cs_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              clr_all
);
  logic [2:0]        pins_s;
  logic              word_done;
  logic [WORD_W-1:0] word_q;
  logic              cmd_fire;
  logic [ADDR_W-1:0] cmd_addr;
  logic [WORD_W-1:0] cmd_data;

  osd_ld_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_cs_n, ser_clk, ser_dat}),
    .q(pins_s)
  );

  osd_ld_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(pins_s[2]), .sclk_s(pins_s[1]), .sdat_s(pins_s[0]),
    .word_done(word_done), .word_q(word_q)
  );

  osd_ld_framer #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SPACE(SPACE), .RAM_WORDS(RAM_WORDS),
    .WIDE_BASE(WIDE_BASE), .RAM_DW(RAM_DW), .CTRL_DW(CTRL_DW), .WIDE_DW(WIDE_DW)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_n_s(pins_s[2]),
    .word_done(word_done), .word_q(word_q),
    .cmd_fire(cmd_fire), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  osd_ld_outslot #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR), .CLR_BIT(CLR_BIT)
  ) u_slot (
    .clk(clk), .rst_n(rst_n),
    .cmd_fire(cmd_fire), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .clr_all(clr_all)
  );
endmodule

// File: rtl/osd_ld_checker.sv
module osd_ld_checker #(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int SPACE     = 192,
  parameter int RAM_WORDS = 176,
  parameter int WIDE_BASE = 188,
  parameter int RAM_DW    = 8,
  parameter int CTRL_DW   = 11,
  parameter int WIDE_DW   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              clr_all
);
  function automatic logic [WORD_W-1:0] keep(input logic [ADDR_W-1:0] a);
    if (int'(a) < RAM_WORDS)      return WORD_W'((64'd1 << RAM_DW) - 1);
    else if (int'(a) < WIDE_BASE) return WORD_W'((64'd1 << CTRL_DW) - 1);
    else                          return WORD_W'((64'd1 << WIDE_DW) - 1);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) p_idle_in_reset_r1: assert (!wr_valid && !clr_all);
  end

  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_in_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> int'(wr_addr) < SPACE);

  p_trimmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data & ~keep(wr_addr)) == '0);

  p_clr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !clr_all);
endmodule

bind osd_serial_loader osd_ld_checker #(
  .WORD_W(WORD_W), .ADDR_W(ADDR_W), .SPACE(SPACE), .RAM_WORDS(RAM_WORDS),
  .WIDE_BASE(WIDE_BASE), .RAM_DW(RAM_DW), .CTRL_DW(CTRL_DW), .WIDE_DW(WIDE_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .clr_all(clr_all)
);

// File: tb/tb_osd_serial_loader.sv
module tb_osd_serial_loader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_cs_n = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_dat = 1'b0;
  logic        wr_ready = 1'b1;
  logic        wr_valid;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;
  logic        clr_all;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_serial_loader dut (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(ser_cs_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .clr_all(clr_all)
  );

  int checks = 0, fails = 0;
  int q_addr[$], q_data[$];
  int exp_clr = 0, seen_clr = 0, beats = 0;
  int m_phase = 0, m_addr = 0;
  bit hold_mode = 0, busy = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  function automatic int keep(input int a);
    if (a < 176) return 'hFF;
    else if (a < 188) return 'h7FF;
    else return 'hFFF;
  endfunction

  // per-clock comparison of every accepted beat against the model queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (clr_all) seen_clr++;
      if (wr_valid && wr_ready) begin
        beats++;
        if (q_addr.size() == 0) begin
          chk(0, cur_req, "unexpected write", {wr_addr, wr_data}, -1);
        end else begin
          int ea, ed;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          chk(int'(wr_addr) == ea && int'(wr_data) == ed, cur_req, "write addr/data",
              {wr_addr, wr_data}, (ea << 16) | ed);
        end
      end
    end
  end

  task automatic send_bits(input logic [15:0] w, input int nbits, input bit measure);
    for (int i = 15; i > 15 - nbits; i--) begin
      ser_dat = w[i];
      tick(3);
      ser_clk = 1'b1;
      if (measure && i == 0) begin
        int got;
        got = 99;
        for (int c = 1; c <= 6; c++) begin
          @(negedge clk);
          if (wr_valid && got == 99) got = c;
        end
        chk(got <= 6, "R10", "cycles to beat", got, 6);
        tick(1);
      end else begin
        tick(4);
      end
      ser_clk = 1'b0;
      tick(1);
    end
  endtask

  task automatic begin_xfer();
    ser_cs_n = 1'b0;
    m_phase = 0;
    tick(4);
  endtask

  task automatic end_xfer();
    ser_cs_n = 1'b1;
    tick(8);
  endtask

  task automatic send_word(input logic [15:0] w);
    bit emit;
    int d;
    emit = 0;
    if (m_phase == 0) begin
      if (w[15:8] == 8'h00) begin
        m_addr = int'(w[7:0]);
        m_phase = 1;
      end else m_phase = 2;
    end else if (m_phase == 1) begin
      if (m_addr < 192) begin
        d = int'(w) & keep(m_addr);
        if (m_addr == 190 && d[5]) exp_clr++;
        if (!(hold_mode && busy)) begin
          q_addr.push_back(m_addr);
          q_data.push_back(d);
          if (hold_mode) busy = 1;
          else emit = 1;
        end
        m_addr++;
      end
    end
    send_bits(w, 16, emit);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(5);
    chk(!wr_valid && !clr_all, "R1", "outputs during reset", {wr_valid, clr_all}, 0);
    rst_n = 1'b1;
    tick(4);
    chk(!wr_valid && !clr_all, "R1", "outputs after reset", {wr_valid, clr_all}, 0);

    // R2: clock edges with chip select high have no effect
    cur_req = "R2";
    for (int k = 0; k < 20; k++) begin
      ser_dat = k[0];
      tick(3); ser_clk = 1'b1; tick(3); ser_clk = 1'b0; tick(1);
    end
    tick(6);
    chk(beats == 0, "R2", "beats while deselected", beats, 0);

    // R4 R5: stream across the RAM / control boundary
    cur_req = "R4";
    begin_xfer();
    send_word(16'h00AE);
    send_word(16'hABCD);
    send_word(16'h1234);
    send_word(16'hFFFF);
    send_word(16'h0777);
    end_xfer();
    chk(beats == 4, "R4", "beats in first stream", beats, 4);

    cur_req = "R5";
    begin_xfer();
    send_word(16'h00BA);
    send_word(16'hFFFF);
    send_word(16'hF9A5);
    send_word(16'hFFFF);
    send_word(16'h8C3C);
    end_xfer();

    // R9 R6: clear bit, then run past the end of the space
    cur_req = "R9";
    begin_xfer();
    send_word(16'h00BE);
    send_word(16'h0020);
    send_word(16'hFFFF);
    cur_req = "R6";
    send_word(16'h1111);
    send_word(16'h2222);
    end_xfer();
    chk(seen_clr == 1, "R9", "clear pulses", seen_clr, 1);
    chk(q_addr.size() == 0, "R6", "pending beats after end of space", q_addr.size(), 0);

    cur_req = "R6";
    begin_xfer();
    send_word(16'h00F0);
    send_word(16'h0055);
    end_xfer();
    chk(beats == 10, "R6", "beats after out-of-space write", beats, 10);

    // R3: location word with nonzero upper byte poisons the transfer
    cur_req = "R3";
    begin_xfer();
    send_word(16'h0105);
    send_word(16'h0042);
    send_word(16'h0043);
    end_xfer();
    chk(beats == 10, "R3", "beats after bad location word", beats, 10);
    begin_xfer();
    send_word(16'h0003);
    send_word(16'h0044);
    end_xfer();

    // R7: partial word discarded at chip-select rise
    cur_req = "R7";
    begin_xfer();
    send_word(16'h0010);
    send_bits(16'hFFFF, 7, 1'b0);
    end_xfer();
    begin_xfer();
    send_word(16'h0020);
    send_word(16'h1234);
    end_xfer();
    chk(beats == 12, "R7", "beats after partial word", beats, 12);

    // R8: hold under back-pressure, drop, advance
    cur_req = "R8";
    wr_ready = 1'b0;
    hold_mode = 1;
    busy = 0;
    begin_xfer();
    send_word(16'h0005);
    send_word(16'h00AA);
    send_word(16'h00BB);
    tick(3);
    chk(wr_valid && wr_addr == 8'h05 && wr_data == 16'h00AA, "R8", "held beat",
        {wr_valid, wr_addr, wr_data}, {1'b1, 8'h05, 16'h00AA});
    wr_ready = 1'b1;
    tick(2);
    hold_mode = 0;
    busy = 0;
    send_word(16'h00CC);
    end_xfer();

    tick(20);
    chk(q_addr.size() == 0, "R4", "unconsumed expected beats", q_addr.size(), 0);
    chk(seen_clr == exp_clr, "R9", "total clear pulses", seen_clr, exp_clr);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule